// File: doc/BRIEF.md
# Masked Watchpoint Comparator Unit

This block watches the program counter and the data-bus access stream of a processor core and raises debug events when configured conditions occur. It holds four comparators. Each one has a 32-bit reference value, a mask size that discards low address bits, and a 4-bit mode code. The mode code chooses what the comparator watches (PC, data reads, data writes, or either kind of access). It also chooses whether a hit requests a halt or fires a trigger output. A sticky per-comparator hit flag records that the condition occurred, and reading the comparator's control register clears the flag.

Two comparators have extra duties. Comparator 0 can compare its reference against an external cycle count instead of an address. Comparator 1 can compare the access data value against its reference. In that mode, one or two other comparators, named by link fields, supply the address qualification for the value match. Those linked comparators then stop acting on their own.

Configuration goes through a small register port: a comparator index, a register select and a combinational read path. Each event appears as a one-cycle pulse in the cycle after the access that caused it.

Top module: `wpt_unit`

## Requirements
- R1: After reset, every reference, mask and control register reads zero, all hit flags are clear, and `halt_pulse` and `trig_pulse` are low.
- R2: An address matches when it equals the reference once the low `mask` bits of both are discarded (mask 0 to 15; select 1 is the mask register, bits [3:0]).
- R3: A data access of size code 0/1/2 (byte/halfword/word) matches if any byte it covers lies in the masked reference range. For example, reference 3 matches a word read at address 0 but not a byte read at address 0.
- R4: Mode codes 4, 5, 6 and 7 (control bits [3:0]) watch PC, read, write and read-or-write. A hit gives a one-cycle `halt_pulse` in the cycle after the access.
- R5: Mode codes 8, 9, 10 and 11 watch the same four conditions but pulse `trig_pulse` instead of `halt_pulse`.
- R6: Mode code 0 and codes 1-3 and 12-15 raise no pulse and never set the hit flag.
- R7: A comparator's hit flag (control bit 31) is set by its condition and stays set until the control register (select 2) of that comparator is read. The read returns the flag and then clears it.
- R8: When control bit 4 of comparator 0 is set, its reference, masked as in R2, is compared against `cycle_count` every cycle in place of any address. On the other comparators bit 4 is not stored and reads 0.
- R9: When control bit 5 of comparator 1 is set, comparator 1 hits on a read (code 5/9), write (6/10) or either (7/11) whose data equals its reference at size code [9:8] = 0 byte, 1 halfword, 2 word (code 3 never matches). The access address must also hit the comparator named in bits [15:12].
- R10: A value match (R9) ignores accesses with `bus_fault` high. PC and plain address matches happen whether or not a fault is flagged.
- R11: The comparator named in bits [19:16] of comparator 1 also qualifies the value match, but only while bit 6 is set.
- R12: While value matching is on, the comparators named by active link fields (other than comparator 1) raise no pulse and set no flag of their own.
- R13: Hits of several comparators in one cycle are ORed into one pulse per output, and each hitting comparator sets its own flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe (clears hit flag on control read) |
| cfg_idx | input | 2 | Comparator index |
| cfg_sel | input | 2 | Register select: 0 reference, 1 mask, 2 control |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| bus_valid | input | 1 | Data access present this cycle |
| bus_addr | input | 32 | Data access address |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_write | input | 1 | 1 write, 0 read |
| bus_fault | input | 1 | Access faulted |
| bus_data | input | 32 | Access data value |
| pc_valid | input | 1 | PC input valid this cycle |
| pc_value | input | 32 | Executed instruction address |
| cycle_count | input | 32 | External cycle count |
| halt_pulse | output | 1 | One-cycle halt request |
| trig_pulse | output | 1 | One-cycle trigger output |

## Verification
Plain address watching is driven with byte, halfword and word accesses just inside and just outside the masked range. These cases separate a mask error from a size-overlap error. Reads and writes are applied under each direction code, and the same conditions are applied under watch and trigger codes, to show that direction decoding and output routing are independent. Value matching is tried with matching and mismatching data, with a faulting access, with an address that misses the link, and with the second link enabled and disabled. A write to the linked address checks that the overridden comparator stays silent. Cycle matching, inert codes and simultaneous hits are then checked through both pulses and the read-back flags.

// File: rtl/wpt_pkg.sv
// Shared types and helpers for the masked watchpoint comparator unit.
// Assumes 32-bit addresses and data and a 4-bit mask-size field.
package wpt_pkg;
    localparam int ADDR_W = 32;
    localparam int MASK_W = 4;
    localparam int CODE_W = 4;
    localparam int LINK_W = 4;

    typedef struct packed {
        logic [ADDR_W-1:0] ref_val;
        logic [MASK_W-1:0] mask;
        logic [CODE_W-1:0] code;
        logic              cyc_sel;
        logic              val_en;
        logic              link_b_en;
        logic [1:0]        val_size;
        logic [LINK_W-1:0] link_a;
        logic [LINK_W-1:0] link_b;
    } cmp_cfg_t;

    // Bits kept for comparison once the low n bits are discarded.
    function automatic logic [ADDR_W-1:0] keep_mask(input logic [MASK_W-1:0] n);
        return ~((ADDR_W'(1) << n) - ADDR_W'(1));
    endfunction
endpackage

// File: rtl/wpt_regs.sv
// Register storage for all comparators plus the sticky hit flags.
// Assumes one register access per cycle; reads are combinational and a
// control read clears the flag at the next edge unless a new hit arrives.
module wpt_regs
    import wpt_pkg::*;
#(
    parameter int NUM_CMP = 4,
    localparam int IDX_W = $clog2(NUM_CMP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [1:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic [NUM_CMP-1:0] evt,
    output cmp_cfg_t          cfg_o [NUM_CMP],
    output logic [31:0]       cfg_rdata
);
    localparam logic [1:0] SEL_REF  = 2'd0;
    localparam logic [1:0] SEL_MASK = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;

    logic [NUM_CMP-1:0] matched;

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
        cmp_cfg_t cfg_q;
        logic     wr_here;
        logic     clr_here;

        assign wr_here  = cfg_wr && (cfg_idx == IDX_W'(i));
        assign clr_here = cfg_rd && (cfg_idx == IDX_W'(i)) && (cfg_sel == SEL_CTRL);

        // Configuration fields; special bits exist only on their comparator.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q <= '0;
            end else if (wr_here) begin
                case (cfg_sel)
                    SEL_REF:  cfg_q.ref_val <= cfg_wdata;
                    SEL_MASK: cfg_q.mask    <= cfg_wdata[MASK_W-1:0];
                    SEL_CTRL: begin
                        cfg_q.code <= cfg_wdata[CODE_W-1:0];
                        if (i == 0) cfg_q.cyc_sel <= cfg_wdata[4];
                        if (i == 1) begin
                            cfg_q.val_en    <= cfg_wdata[5];
                            cfg_q.link_b_en <= cfg_wdata[6];
                            cfg_q.val_size  <= cfg_wdata[9:8];
                            cfg_q.link_a    <= cfg_wdata[15:12];
                            cfg_q.link_b    <= cfg_wdata[19:16];
                        end
                    end
                    default: ;
                endcase
            end
        end

        // Sticky hit flag: a new hit wins over a clearing read.
        always_ff @(posedge clk) begin
            if (!rst_n)        matched[i] <= 1'b0;
            else if (evt[i])   matched[i] <= 1'b1;
            else if (clr_here) matched[i] <= 1'b0;
        end

        assign cfg_o[i] = cfg_q;

        a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (matched[i] && !clr_here) |=> matched[i]);
        a_r7_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_here && !evt[i]) |=> !matched[i]);
        if (i != 0) begin : g_nocyc
            a_r8_cyc_only_first: assert property (@(posedge clk) disable iff (!rst_n)
                !cfg_q.cyc_sel);
        end
    end

    // Read data mux over the selected comparator.
    always_comb begin
        cmp_cfg_t c;
        c = cfg_o[cfg_idx];
        cfg_rdata = '0;
        case (cfg_sel)
            SEL_REF:  cfg_rdata = c.ref_val;
            SEL_MASK: cfg_rdata[MASK_W-1:0] = c.mask;
            SEL_CTRL: begin
                cfg_rdata[31]    = matched[cfg_idx];
                cfg_rdata[19:16] = c.link_b;
                cfg_rdata[15:12] = c.link_a;
                cfg_rdata[9:8]   = c.val_size;
                cfg_rdata[6]     = c.link_b_en;
                cfg_rdata[5]     = c.val_en;
                cfg_rdata[4]     = c.cyc_sel;
                cfg_rdata[3:0]   = c.code;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/wpt_match.sv
// Address, PC and cycle comparison for one comparator.
// Assumes naturally aligned accesses: the access size widens the ignored
// low-bit range so that any covered byte inside the reference range hits.
module wpt_match
    import wpt_pkg::*;
(
    input  cmp_cfg_t          cfg,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [ADDR_W-1:0] pc_value,
    input  logic [ADDR_W-1:0] cycle_count,
    output logic              addr_hit,
    output logic              pc_hit,
    output logic              cyc_hit
);
    logic [MASK_W-1:0] eff_bits;
    logic [ADDR_W-1:0] keep_acc;
    logic [ADDR_W-1:0] keep_ref;

    // Masked equality for data address, PC and cycle count.
    always_comb begin
        eff_bits = (MASK_W'(bus_size) > cfg.mask) ? MASK_W'(bus_size) : cfg.mask;
        keep_acc = keep_mask(eff_bits);
        keep_ref = keep_mask(cfg.mask);
        addr_hit = ((bus_addr ^ cfg.ref_val) & keep_acc) == '0;
        pc_hit   = ((pc_value ^ cfg.ref_val) & keep_ref) == '0;
        cyc_hit  = ((cycle_count ^ cfg.ref_val) & keep_ref) == '0;
    end
endmodule

// File: rtl/wpt_event.sv
// Mode decoding, value matching with links, and output pulse registers.
// Assumes comparator 1 is the only value-capable one and comparator 0 the
// only cycle-capable one; link indices beyond the comparator count qualify nothing.
module wpt_event
    import wpt_pkg::*;
#(
    parameter int NUM_CMP = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  cmp_cfg_t           cfg [NUM_CMP],
    input  logic [NUM_CMP-1:0] addr_hit,
    input  logic [NUM_CMP-1:0] pc_hit,
    input  logic [NUM_CMP-1:0] cyc_hit,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic               bus_fault,
    input  logic [ADDR_W-1:0]  bus_data,
    input  logic               pc_valid,
    output logic [NUM_CMP-1:0] evt,
    output logic               halt_pulse,
    output logic               trig_pulse
);
    logic               val_on;
    logic               link_ok;
    logic               data_hit;
    logic [NUM_CMP-1:0] ovr;
    logic [NUM_CMP-1:0] is_watch;
    logic [NUM_CMP-1:0] is_trig;

    // Link qualification and override of linked comparators.
    always_comb begin
        val_on  = cfg[1].val_en;
        link_ok = 1'b0;
        ovr     = '0;
        for (int j = 0; j < NUM_CMP; j++) begin
            if (cfg[1].link_a == LINK_W'(j)) begin
                link_ok = link_ok | addr_hit[j];
                if (val_on && j != 1) ovr[j] = 1'b1;
            end
            if (cfg[1].link_b_en && cfg[1].link_b == LINK_W'(j)) begin
                link_ok = link_ok | addr_hit[j];
                if (val_on && j != 1) ovr[j] = 1'b1;
            end
        end
    end

    // Data value comparison at the configured width.
    always_comb begin
        case (cfg[1].val_size)
            2'd0:    data_hit = bus_data[7:0]  == cfg[1].ref_val[7:0];
            2'd1:    data_hit = bus_data[15:0] == cfg[1].ref_val[15:0];
            2'd2:    data_hit = bus_data == cfg[1].ref_val;
            default: data_hit = 1'b0;
        endcase
    end

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_dec
        logic       cond;
        logic [1:0] kind;

        assign kind        = cfg[i].code[1:0];
        assign is_watch[i] = cfg[i].code[3:2] == 2'b01;
        assign is_trig[i]  = cfg[i].code[3:2] == 2'b10;

        // Raw condition for this comparator under its current mode.
        always_comb begin
            logic dir_ok;
            case (kind)
                2'd0:    cond = pc_valid && pc_hit[i];
                2'd1:    cond = bus_valid && !bus_write && addr_hit[i];
                2'd2:    cond = bus_valid && bus_write && addr_hit[i];
                default: cond = bus_valid && addr_hit[i];
            endcase
            if (cfg[i].cyc_sel) cond = cyc_hit[i];
            dir_ok = (kind == 2'd3) || (kind == 2'd1 && !bus_write) || (kind == 2'd2 && bus_write);
            if (i == 1 && val_on)
                cond = bus_valid && !bus_fault && dir_ok && data_hit && link_ok;
        end

        assign evt[i] = cond && (is_watch[i] || is_trig[i]) && !ovr[i];
    end

    // One-cycle pulses, ORed across comparators.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_pulse <= 1'b0;
            trig_pulse <= 1'b0;
        end else begin
            halt_pulse <= |(evt & is_watch);
            trig_pulse <= |(evt & is_trig);
        end
    end

    a_r6_no_watch_code_no_halt: assert property (@(posedge clk) disable iff (!rst_n)
        !(|is_watch) |=> !halt_pulse);
    a_r6_no_trig_code_no_trig: assert property (@(posedge clk) disable iff (!rst_n)
        !(|is_trig) |=> !trig_pulse);
    a_r10_fault_blocks_value: assert property (@(posedge clk) disable iff (!rst_n)
        (val_on && bus_fault && !cfg[1].cyc_sel) |-> !evt[1]);
endmodule

// File: rtl/wpt_unit.sv
// Top of the masked watchpoint comparator unit: register port, one
// comparison slice per comparator and the shared event decoder.
// Assumes at most one PC and one data access per cycle.
module wpt_unit
    import wpt_pkg::*;
#(
    parameter int NUM_CMP = 4,
    localparam int IDX_W = $clog2(NUM_CMP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [1:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              bus_valid,
    input  logic [31:0]       bus_addr,
    input  logic [1:0]        bus_size,
    input  logic              bus_write,
    input  logic              bus_fault,
    input  logic [31:0]       bus_data,
    input  logic              pc_valid,
    input  logic [31:0]       pc_value,
    input  logic [31:0]       cycle_count,
    output logic              halt_pulse,
    output logic              trig_pulse
);
    cmp_cfg_t           cfg [NUM_CMP];
    logic [NUM_CMP-1:0] evt;
    logic [NUM_CMP-1:0] addr_hit;
    logic [NUM_CMP-1:0] pc_hit;
    logic [NUM_CMP-1:0] cyc_hit;

    wpt_regs #(.NUM_CMP(NUM_CMP)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_idx(cfg_idx), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .evt(evt), .cfg_o(cfg), .cfg_rdata(cfg_rdata)
    );

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_slice
        wpt_match u_match (
            .cfg(cfg[i]), .bus_addr(bus_addr), .bus_size(bus_size),
            .pc_value(pc_value), .cycle_count(cycle_count),
            .addr_hit(addr_hit[i]), .pc_hit(pc_hit[i]), .cyc_hit(cyc_hit[i])
        );
    end

    wpt_event #(.NUM_CMP(NUM_CMP)) u_event (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .addr_hit(addr_hit),
        .pc_hit(pc_hit), .cyc_hit(cyc_hit), .bus_valid(bus_valid),
        .bus_write(bus_write), .bus_fault(bus_fault), .bus_data(bus_data),
        .pc_valid(pc_valid), .evt(evt), .halt_pulse(halt_pulse),
        .trig_pulse(trig_pulse)
    );

    a_r4_halt_needs_activity: assert property (@(posedge clk) disable iff (!rst_n)
        halt_pulse |-> $past(bus_valid || pc_valid || cfg[0].cyc_sel));
    a_r13_trig_needs_activity: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> $past(bus_valid || pc_valid || cfg[0].cyc_sel));
endmodule

// File: tb/wpt_unit_test.sv
module wpt_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
    logic [1:0]  cfg_idx = '0, cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        bus_valid = 1'b0, bus_write = 1'b0, bus_fault = 1'b0;
    logic [1:0]  bus_size = '0;
    logic [31:0] bus_addr = '0, bus_data = '0;
    logic        pc_valid = 1'b0;
    logic [31:0] pc_value = '0;
    logic [31:0] cycle_count = 32'hDEAD_0000;
    logic        halt_pulse, trig_pulse;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    typedef struct {
        logic  h;
        logic  t;
        string tag;
    } item_t;
    item_t exp_q [$];

    always #4 clk = ~clk;

    wpt_unit uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_idx(cfg_idx), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_write(bus_write), .bus_fault(bus_fault),
        .bus_data(bus_data), .pc_valid(pc_valid), .pc_value(pc_value),
        .cycle_count(cycle_count), .halt_pulse(halt_pulse), .trig_pulse(trig_pulse)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops the expected pulses for the edge just passed.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            item_t it;
            it = exp_q.pop_front();
            check(halt_pulse === it.h && trig_pulse === it.t, it.tag,
                  {30'd0, halt_pulse, trig_pulse}, {30'd0, it.h, it.t});
        end
    end

    task automatic idle_bus();
        bus_valid = 1'b0; pc_valid = 1'b0; bus_fault = 1'b0;
        cycle_count = 32'hDEAD_0000;
    endtask

    task automatic wr(input int idx, input int sel, input logic [31:0] d);
        @(negedge clk);
        idle_bus();
        cfg_wr = 1'b1; cfg_idx = 2'(idx); cfg_sel = 2'(sel); cfg_wdata = d;
        @(posedge clk); #1;
        cfg_wr = 1'b0;
    endtask

    task automatic rd_check(input int idx, input int sel, input logic [31:0] exp, input string tag);
        @(negedge clk);
        idle_bus();
        cfg_rd = 1'b1; cfg_idx = 2'(idx); cfg_sel = 2'(sel);
        #1 check(cfg_rdata === exp, tag, cfg_rdata, exp);
        @(posedge clk); #1;
        cfg_rd = 1'b0;
    endtask

    // Driver: one cycle of bus/PC stimulus, expected pulses queued.
    task automatic step(input logic bv, input logic [31:0] a, input logic [1:0] sz,
                        input logic w, input logic f, input logic [31:0] d,
                        input logic pv, input logic [31:0] pc, input logic [31:0] cyc,
                        input logic eh, input logic et, input string tag);
        item_t it;
        @(negedge clk);
        bus_valid = bv; bus_addr = a; bus_size = sz; bus_write = w;
        bus_fault = f; bus_data = d; pc_valid = pv; pc_value = pc; cycle_count = cyc;
        @(posedge clk); #1;
        it.h = eh; it.t = et; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic rdacc(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d,
                         input logic eh, input logic et, input string tag);
        step(1, a, sz, 0, 0, d, 0, 0, 32'hDEAD_0000, eh, et, tag);
    endtask

    task automatic wracc(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d,
                         input logic eh, input logic et, input string tag);
        step(1, a, sz, 1, 0, d, 0, 0, 32'hDEAD_0000, eh, et, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(halt_pulse === 1'b0 && trig_pulse === 1'b0, "R1 pulses low", {30'd0, halt_pulse, trig_pulse}, 0);
        for (int i = 0; i < 4; i++) begin
            rd_check(i, 0, 0, "R1 ref zero");
            rd_check(i, 2, 0, "R1 ctrl zero");
        end
        rd_check(0, 1, 0, "R1 mask zero");

        // R2 masked range
        wr(0, 0, 32'h1000_0040); wr(0, 1, 4); wr(0, 2, 5);
        rdacc(32'h1000_004C, 0, 0, 1, 0, "R2 inside masked range");
        rdacc(32'h1000_0050, 0, 0, 0, 0, "R2 above range");
        rdacc(32'h1000_003F, 0, 0, 0, 0, "R2 below range");
        rd_check(0, 2, 32'h8000_0005, "R7 flag set");
        rd_check(0, 2, 32'h0000_0005, "R7 flag cleared by read");

        // R3 size overlap
        wr(0, 0, 3); wr(0, 1, 0);
        rdacc(0, 2, 0, 1, 0, "R3 word covers byte 3");
        rdacc(0, 0, 0, 0, 0, "R3 byte 0 misses");
        rdacc(2, 1, 0, 1, 0, "R3 half at 2 covers 3");
        rdacc(0, 1, 0, 0, 0, "R3 half at 0 misses");

        // R4 direction codes
        wr(0, 2, 6);
        rdacc(0, 2, 0, 0, 0, "R4 write code ignores read");
        wracc(0, 2, 0, 1, 0, "R4 write code write");
        wr(0, 2, 7);
        rdacc(0, 2, 0, 1, 0, "R4 either code read");
        wr(0, 0, 32'h800); wr(0, 2, 4);
        step(1, 32'h9000, 2, 0, 1, 0, 1, 32'h800, 32'hDEAD_0000, 1, 0, "R4 R10 PC hit despite fault");
        step(0, 0, 0, 0, 0, 0, 1, 32'h804, 32'hDEAD_0000, 0, 0, "R4 PC miss");

        // R5 trigger codes
        wr(0, 0, 3); wr(0, 2, 9);
        rdacc(0, 2, 0, 0, 1, "R5 read trigger");
        wr(0, 2, 8);
        step(0, 0, 0, 0, 0, 0, 1, 32'h3, 32'hDEAD_0000, 0, 1, "R5 PC trigger");
        rd_check(0, 2, 32'h8000_0008, "R7 trigger sets flag");

        // R6 inert codes
        wr(0, 2, 0);
        rdacc(0, 2, 0, 0, 0, "R6 disabled");
        wr(0, 2, 2);
        rdacc(0, 2, 0, 0, 0, "R6 code 2 inert");
        wr(0, 2, 13);
        wracc(0, 2, 0, 0, 0, "R6 code 13 inert");
        rd_check(0, 2, 32'h0000_000D, "R6 no flag");

        // R8 cycle match
        wr(0, 0, 100); wr(0, 2, 32'h14);
        step(0, 0, 0, 0, 0, 0, 0, 0, 99, 0, 0, "R8 cycle miss");
        step(0, 0, 0, 0, 0, 0, 0, 0, 100, 1, 0, "R8 cycle hit");
        wr(2, 2, 32'h16);
        rd_check(2, 2, 32'h0000_0006, "R8 bit absent on comparator 2");
        wr(0, 2, 0);
        rd_check(0, 2, 32'h8000_0000, "R8 flag then cleared config");

        // R9 R10 R12 value match
        wr(2, 0, 32'h2000);
        wr(1, 0, 32'h0000_12A5); wr(1, 2, 32'h0000_2025);
        rdacc(32'h2000, 0, 32'hFFFF_FFA5, 1, 0, "R9 byte value hit");
        rdacc(32'h2000, 0, 32'h0000_005A, 0, 0, "R9 value miss");
        wracc(32'h2000, 0, 32'h0000_00A5, 0, 0, "R12 linked comparator silent");
        step(1, 32'h2000, 0, 0, 1, 32'hA5, 0, 0, 32'hDEAD_0000, 0, 0, "R10 faulting value access");
        rdacc(32'h2004, 0, 32'hA5, 0, 0, "R9 link address miss");
        wr(1, 2, 32'h0000_2125);
        rdacc(32'h2000, 1, 32'h0000_12A5, 1, 0, "R9 halfword hit");
        rdacc(32'h2000, 1, 32'h0000_00A5, 0, 0, "R9 halfword miss");
        rd_check(2, 2, 32'h0000_0006, "R12 no flag on linked");

        // R11 second link
        wr(3, 0, 32'h3000); wr(3, 2, 0);
        wr(1, 2, 32'h0003_2025);
        rdacc(32'h3000, 0, 32'hA5, 0, 0, "R11 second link off");
        wr(1, 2, 32'h0003_2065);
        rdacc(32'h3000, 0, 32'hA5, 1, 0, "R11 second link on");
        rd_check(1, 2, 32'h8003_2065, "R11 value flag");

        // R13 simultaneous hits
        wr(1, 2, 0); wr(2, 2, 0);
        wr(0, 0, 32'h4000); wr(0, 2, 7);
        wr(3, 0, 32'h4000); wr(3, 2, 5);
        rdacc(32'h4000, 2, 0, 1, 0, "R13 two watch hits");
        wr(3, 2, 11);
        rdacc(32'h4000, 2, 0, 1, 1, "R13 watch plus trigger");
        rd_check(0, 2, 32'h8000_0007, "R13 flag comparator 0");
        rd_check(3, 2, 32'h8000_000B, "R13 flag comparator 3");

        @(negedge clk); #1;
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule